// File: doc/BRIEF.md
# Privileged Opcode Screening Filter

This block sits beside a processor's bus and watches the byte on the data bus during every instruction-fetch cycle. It recognises instructions that are never acceptable while memory protection is active, and a second group that is acceptable only to the kernel. It also checks the immediate byte of a status-bit set instruction. If that byte would set only the interrupt-disable flag, a user process is trying to mask interrupts.

The bus cycle class, the data byte and the current privilege mode are sampled on each rising clock edge. When a cycle breaks a rule, the block raises a single-cycle violation pulse together with a class code on the following cycle. Stopping the offending instruction is left to the logic that receives the pulse.

Top module: `opcode_screen`

## Requirements
- R1: While reset is asserted, and on the first cycle after it, `violation` is 0 and `violClass` is 0.
- R2: In user mode (`privMode`=1) or kernel mode (`privMode`=2), an instruction-fetch cycle (`busCycle`=3) whose byte is 0x02, 0x42, 0xDB or 0xFB raises `violation` on the next cycle with `violClass`=1.
- R3: An instruction-fetch cycle whose byte is 0x22, 0x40, 0x5C, 0x6B, 0x78 or 0xDC raises `violation` on the next cycle with `violClass`=2 in user mode only. In kernel mode the same cycle is not reported.
- R4: Suppose an instruction-fetch of 0xE2 is followed on the very next cycle by an operand-fetch cycle (`busCycle`=1) carrying exactly 0x04 in user mode. Then `violation` rises on the cycle after the operand fetch with `violClass`=3. Any other operand byte, and any non-user mode on the operand cycle, gives no report.
- R5: The armed state left by an 0xE2 fetch lasts one cycle. An idle (`busCycle`=0) or data (`busCycle`=2) cycle in between disarms it. A further instruction fetch also disarms it, unless that fetch is itself 0xE2.
- R6: In real mode (`privMode`=0) no violation is ever reported.
- R7: A forbidden byte on an idle, data or operand-fetch cycle produces no report, except for the case in R4.
- R8: `violClass` is nonzero exactly on the cycles where `violation` is 1. Each offending bus cycle produces one pulse of one cycle.
- R9: `privMode`=3 behaves as kernel mode: the R2 list is reported, and the R3 list and the R4 case are not.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| busCycle | input | 2 | Cycle class: 0 idle, 1 operand fetch, 2 data access, 3 instruction fetch |
| dataByte | input | 8 | Byte on the data bus this cycle |
| privMode | input | 2 | 0 real, 1 user, 2 kernel, 3 treated as kernel |
| violation | output | 1 | One-cycle pulse, one cycle after the offending bus cycle |
| violClass | output | 2 | 0 none, 1 never allowed, 2 user-forbidden, 3 interrupt-mask attempt |

## Verification
In one cycle, the filter can retire an armed status-set check and decode a new instruction fetch. This happens when 0xE2 is followed directly by another instruction fetch instead of its operand. The bench drives 0xE2 followed by 0xE2 and then an operand of 0x04, which must still report class 3 because the second fetch re-arms the filter. It also drives 0xE2 followed by a fetch of a forbidden byte, which must report that byte's own class while leaving the filter disarmed. Every mode, cycle class and byte value is also swept with the filter both armed and disarmed beforehand, and each outcome is compared with a model computed from the rule lists.

// File: rtl/opscreen_pkg.sv
package opscreen_pkg;
  localparam int BYTE_W = 8;
  localparam int N_HARD = 4;
  localparam int N_USER = 6;

  typedef logic [BYTE_W-1:0] byte_t;

  // Forbidden whenever protection is on
  localparam byte_t HARD_OPS [N_HARD] = '{8'h02, 8'h42, 8'hDB, 8'hFB};
  // Forbidden to user processes only
  localparam byte_t USER_OPS [N_USER] = '{8'h22, 8'h40, 8'h5C, 8'h6B, 8'h78, 8'hDC};
  localparam byte_t SETBITS_OP = 8'hE2;
  localparam byte_t IRQMASK_IMM = 8'h04;

  typedef enum logic [1:0] {
    CYC_IDLE    = 2'd0,
    CYC_OPERAND = 2'd1,
    CYC_DATA    = 2'd2,
    CYC_OPCODE  = 2'd3
  } busCycle_e;

  typedef enum logic [1:0] {
    MODE_REAL   = 2'd0,
    MODE_USER   = 2'd1,
    MODE_KERNEL = 2'd2,
    MODE_SPARE  = 2'd3
  } privMode_e;

  typedef enum logic [1:0] {
    VC_NONE    = 2'd0,
    VC_NEVER   = 2'd1,
    VC_USER    = 2'd2,
    VC_IRQMASK = 2'd3
  } violClass_e;

  typedef struct packed {
    logic opcodeStrobe;   // instruction fetch this cycle
    logic operandStrobe;  // operand fetch right after a status-set fetch
    logic protMode;       // any mode other than real
    logic userMode;       // user mode
  } screenStrobes_t;
endpackage

// File: rtl/opscreen_ctrl.sv
module opscreen_ctrl
  import opscreen_pkg::*;
(
  input  logic           clk,
  input  logic           rst_n,
  input  busCycle_e      busCycle,
  input  privMode_e      privMode,
  input  logic           setBitsSeen,
  output screenStrobes_t strobes
);
  logic armed;

  // One cycle of memory: only an instruction fetch of the status-set
  // opcode arms; every other cycle, including the operand fetch, disarms.
  always_ff @(posedge clk) begin
    if (!rst_n) armed <= 1'b0;
    else        armed <= (busCycle == CYC_OPCODE) && setBitsSeen;
  end

  always_comb begin
    strobes.opcodeStrobe  = (busCycle == CYC_OPCODE);
    strobes.operandStrobe = (busCycle == CYC_OPERAND) && armed;
    strobes.protMode      = (privMode != MODE_REAL);
    strobes.userMode      = (privMode == MODE_USER);
  end
endmodule

// File: rtl/opscreen_dpath.sv
module opscreen_dpath
  import opscreen_pkg::*;
(
  input  logic           clk,
  input  logic           rst_n,
  input  byte_t          dataByte,
  input  screenStrobes_t strobes,
  output logic           setBitsSeen,
  output logic           violation,
  output violClass_e     violClass
);
  logic [N_HARD-1:0] hardHit;
  logic [N_USER-1:0] userHit;

  for (genvar i = 0; i < N_HARD; i++) begin : g_hard
    assign hardHit[i] = (dataByte == HARD_OPS[i]);
  end
  for (genvar j = 0; j < N_USER; j++) begin : g_user
    assign userHit[j] = (dataByte == USER_OPS[j]);
  end

  assign setBitsSeen = (dataByte == SETBITS_OP);

  logic neverHit, userOnlyHit, maskHit;
  violClass_e classNext;

  always_comb begin
    neverHit    = strobes.opcodeStrobe && strobes.protMode && (|hardHit);
    userOnlyHit = strobes.opcodeStrobe && strobes.userMode && (|userHit);
    maskHit     = strobes.operandStrobe && strobes.userMode && (dataByte == IRQMASK_IMM);
    if (neverHit)         classNext = VC_NEVER;
    else if (userOnlyHit) classNext = VC_USER;
    else if (maskHit)     classNext = VC_IRQMASK;
    else                  classNext = VC_NONE;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      violation <= 1'b0;
      violClass <= VC_NONE;
    end else begin
      violation <= (classNext != VC_NONE);
      violClass <= classNext;
    end
  end
endmodule

// File: rtl/opcode_screen.sv
module opcode_screen
  import opscreen_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] busCycle,
  input  logic [7:0] dataByte,
  input  logic [1:0] privMode,
  output logic       violation,
  output logic [1:0] violClass
);
  screenStrobes_t strobes;
  logic           setBitsSeen;
  violClass_e     classOut;

  opscreen_ctrl u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .busCycle   (busCycle_e'(busCycle)),
    .privMode   (privMode_e'(privMode)),
    .setBitsSeen(setBitsSeen),
    .strobes    (strobes)
  );

  opscreen_dpath u_dpath (
    .clk        (clk),
    .rst_n      (rst_n),
    .dataByte   (dataByte),
    .strobes    (strobes),
    .setBitsSeen(setBitsSeen),
    .violation  (violation),
    .violClass  (classOut)
  );

  assign violClass = classOut;
endmodule

// File: rtl/opcode_screen_chk.sv
module opcode_screen_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] busCycle,
  input logic [7:0] dataByte,
  input logic [1:0] privMode,
  input logic       violation,
  input logic [1:0] violClass
);
  // R8: class code present exactly with the pulse
  p_class_with_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    violation == (violClass != 2'd0));

  // R6: real mode on the offending cycle never reports
  p_real_silent_r6: assert property (@(posedge clk) disable iff (!rst_n)
    violation |-> ($past(privMode) != 2'd0));

  // R7: opcode classes come only from instruction-fetch cycles
  p_fetch_only_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (violClass == 2'd1 || violClass == 2'd2) |-> ($past(busCycle) == 2'd3));

  // R3: user-only class needs user mode
  p_user_tier_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (violClass == 2'd2) |-> ($past(privMode) == 2'd1));

  // R4: mask-attempt class needs the fetch/operand pair with the mask byte
  p_irqmask_pair_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (violClass == 2'd3) |-> ($past(busCycle) == 2'd1 && $past(dataByte) == 8'h04 &&
                             $past(privMode) == 2'd1 && $past(busCycle, 2) == 2'd3 &&
                             $past(dataByte, 2) == 8'hE2));
endmodule

bind opcode_screen opcode_screen_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .busCycle (busCycle),
  .dataByte (dataByte),
  .privMode (privMode),
  .violation(violation),
  .violClass(violClass)
);

// File: tb/test_opcode_screen.sv
`timescale 1ns/1ps
module test_opcode_screen;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] busCycle = 2'd0;
  logic [7:0] dataByte = 8'd0;
  logic [1:0] privMode = 2'd0;
  logic       violation;
  logic [1:0] violClass;
  int nChecks = 0;
  int nFails = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  opcode_screen i_opcode_screen (
    .clk(clk), .rst_n(rst_n), .busCycle(busCycle), .dataByte(dataByte),
    .privMode(privMode), .violation(violation), .violClass(violClass)
  );

  function automatic bit isHard(input logic [7:0] b);
    return b == 8'h02 || b == 8'h42 || b == 8'hDB || b == 8'hFB;
  endfunction
  function automatic bit isUser(input logic [7:0] b);
    return b == 8'h22 || b == 8'h40 || b == 8'h5C || b == 8'h6B || b == 8'h78 || b == 8'hDC;
  endfunction

  // Expected class for one cycle, given whether the previous cycle armed the filter
  function automatic logic [1:0] expClass(input bit armed, input logic [1:0] m,
                                          input logic [1:0] c, input logic [7:0] b);
    if (c == 2'd3 && m != 2'd0 && isHard(b)) return 2'd1;
    if (c == 2'd3 && m == 2'd1 && isUser(b)) return 2'd2;
    if (c == 2'd1 && armed && m == 2'd1 && b == 8'h04) return 2'd3;
    return 2'd0;
  endfunction

  task automatic check(input string req, input logic [1:0] exp);
    nChecks++;
    if (violation !== (exp != 2'd0) || violClass !== exp) begin
      nFails++;
      $display("FAIL %s: got violation=%0b class=%0d expected violation=%0b class=%0d",
               req, violation, violClass, exp != 2'd0, exp);
    end
  endtask

  // Drive one bus cycle; afterwards the outputs show its result
  task automatic cyc(input logic [1:0] c, input logic [7:0] b, input logic [1:0] m);
    @(negedge clk);
    busCycle = c; dataByte = b; privMode = m;
    @(posedge clk);
    #1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      nFails++; nChecks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  end

  initial begin
    // R1: reset state
    repeat (3) @(posedge clk);
    #1 check("R1", 2'd0);
    busCycle = 2'd3; dataByte = 8'h02; privMode = 2'd1;
    @(posedge clk); #1 check("R1", 2'd0);
    @(negedge clk); rst_n = 1'b1; busCycle = 2'd0;
    @(posedge clk); #1 check("R1", 2'd0);

    // Sweep: every mode, cycle class and byte, disarmed and armed beforehand
    for (int m = 0; m < 4; m++) begin
      for (int c = 0; c < 4; c++) begin
        for (int b = 0; b < 256; b++) begin
          for (int a = 0; a < 2; a++) begin
            logic [1:0] e;
            string req;
            if (a == 1) cyc(2'd3, 8'hE2, 2'(m));
            else        cyc(2'd0, 8'hE2, 2'(m));
            check("R7", 2'd0);
            cyc(2'(c), 8'(b), 2'(m));
            e = expClass(a == 1, 2'(m), 2'(c), 8'(b));
            if (e == 2'd1)      req = "R2";
            else if (e == 2'd2) req = "R3";
            else if (e == 2'd3) req = "R4";
            else if (m == 0)    req = "R6";
            else if (m == 3)    req = "R9";
            else                req = "R7";
            check(req, e);
          end
        end
      end
    end

    // R5: an intervening data or idle cycle disarms
    cyc(2'd3, 8'hE2, 2'd1); cyc(2'd2, 8'h04, 2'd1); cyc(2'd1, 8'h04, 2'd1); check("R5", 2'd0);
    cyc(2'd3, 8'hE2, 2'd1); cyc(2'd0, 8'h04, 2'd1); cyc(2'd1, 8'h04, 2'd1); check("R5", 2'd0);
    // R5: a repeated status-set fetch re-arms
    cyc(2'd3, 8'hE2, 2'd1); cyc(2'd3, 8'hE2, 2'd1); check("R5", 2'd0);
    cyc(2'd1, 8'h04, 2'd1); check("R5", 2'd3);
    // R8: pulse lasts one cycle
    cyc(2'd0, 8'h00, 2'd1); check("R8", 2'd0);
    // R5: a forbidden fetch right after the status-set fetch reports itself and disarms
    cyc(2'd3, 8'hE2, 2'd1); cyc(2'd3, 8'hDB, 2'd1); check("R5", 2'd1);
    cyc(2'd1, 8'h04, 2'd1); check("R5", 2'd0);
    // R8: back-to-back offending fetches give back-to-back pulses
    cyc(2'd3, 8'h78, 2'd1); check("R8", 2'd2);
    cyc(2'd3, 8'hFB, 2'd2); check("R8", 2'd1);
    cyc(2'd3, 8'h78, 2'd2); check("R3", 2'd0);
    // R9: spare mode acts as kernel
    cyc(2'd3, 8'hE2, 2'd3); cyc(2'd1, 8'h04, 2'd3); check("R9", 2'd0);
    cyc(2'd3, 8'h42, 2'd3); check("R9", 2'd1);
    // R4: arming in kernel, operand in user still reports (mode judged on operand cycle)
    cyc(2'd3, 8'hE2, 2'd2); cyc(2'd1, 8'h04, 2'd1); check("R4", 2'd3);
    cyc(2'd3, 8'hE2, 2'd1); cyc(2'd1, 8'h24, 2'd1); check("R4", 2'd0);

    finished = 1'b1;
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end
endmodule